// File: doc/BRIEF.md
# Subtract, Negate and Extend Execution Unit

This block is one execution slice of a 32-bit RISC core. Each cycle it may accept a 16-bit instruction word. It decodes the word, reads two operands from its own 16-entry by 32-bit register file, and computes the result in the same cycle. On the next clock edge it writes the result to the destination register. The operations are decrement-and-test, sign and zero extension of a byte or a halfword, negate, negate with borrow, and three kinds of subtraction.

A single status bit, T, is shared by the operations. Which role it plays depends on the opcode:
- After decrement-and-test, T holds the zero test of the result.
- For the two borrow-chained operations, T is the borrow in and the borrow out.
- For the checked subtraction, T is the signed overflow flag.
- The other operations leave T alone.

Other units of the core deliver results through a second write port on the register file. A combinational peek port reads any register.

The destination field sits in bits 11:8 of the word and the source field in bits 7:4. Bits 15:12 hold the major opcode. For the decrement-and-test operation, bits 7:0 carry the sub-code; for all other operations, bits 3:0 do.

Top module: `sne_unit`

## Requirements
- R1: Word 0x4n10 writes Rn-1 to Rn. T becomes 1 when that result is zero and 0 otherwise.
- R2: Word 0x6nmE writes Rm[7:0] sign-extended to 32 bits into Rn. Word 0x6nmF does the same for Rm[15:0]. T is unchanged.
- R3: Word 0x6nmC writes Rm[7:0] zero-extended into Rn. Word 0x6nmD does the same for Rm[15:0]. T is unchanged.
- R4: Word 0x6nmB writes 0-Rm into Rn and leaves T unchanged.
- R5: Word 0x6nmA writes 0-Rm-T into Rn. T becomes the borrow out of that 32-bit subtraction.
- R6: Word 0x3nm8 writes Rn-Rm into Rn and leaves T unchanged.
- R7: Word 0x3nmA writes Rn-Rm-T into Rn. T becomes the borrow out.
- R8: Word 0x3nmB writes Rn-Rm into Rn. T becomes 1 exactly when the two's-complement result overflowed. Overflow means the operands differ in sign and the result's sign differs from Rn's sign.
- R9: A word that matches none of the encodings above writes no register and leaves T unchanged. A valid-low cycle does the same.
- R10: When Rn and Rm name the same register, both operands are the value held before the write.
- R11: While rst_n is low at a clock edge, T and all 16 registers clear to zero.
- R12: The external port writes ext_data into register ext_idx when ext_we is high. If the instruction writes the same register in the same cycle, the instruction result wins.
- R13: A result is computed in one cycle. It is visible on peek_data, and its T effect on t_flag, right after the clock edge that accepts the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 16 | Instruction word |
| ext_we | input | 1 | Write enable from another unit |
| ext_idx | input | 4 | Register index for the external write |
| ext_data | input | 32 | Data for the external write |
| peek_idx | input | 4 | Register index to observe |
| peek_data | output | 32 | Contents of register peek_idx |
| wb_en | output | 1 | This cycle's instruction writes a register |
| wb_data | output | 32 | Result being written this cycle |
| t_flag | output | 1 | Current T bit |

## Verification
Two things can land in the same cycle: an instruction write-back and an external write. The bench provokes this by issuing a subtract to R1 while the external port also targets R1. It expects the register to hold the subtract result, not the external value. A second case aims the external port at a different register in the same cycle, and the bench expects both values to land. Same-register operand reads are also checked, because the write and both reads meet on one entry in one cycle.

// File: rtl/sne_pkg.sv
// sne_pkg: shared operation codes for the subtract/negate/extend unit.
// Assumes 16-bit instruction words with fields laid out as in the brief.
package sne_pkg;
    typedef enum logic [3:0] {
        OP_NONE,
        OP_DT,
        OP_EXTSB,
        OP_EXTSW,
        OP_EXTUB,
        OP_EXTUW,
        OP_NEG,
        OP_NEGC,
        OP_SUB,
        OP_SUBC,
        OP_SUBV
    } sne_op_e;

    localparam int INSTR_W = 16;
endpackage

// File: rtl/sne_decode.sv
// sne_decode: turns an instruction word into an operation and two register
// indices. Assumes the destination is in bits 11:8 and the source in bits 7:4.
// Any word not recognised decodes to OP_NONE.
module sne_decode
    import sne_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [INSTR_W-1:0] instr,
    output sne_op_e            op,
    output logic [IDX_W-1:0]   rn,
    output logic [IDX_W-1:0]   rm
);
    localparam logic [3:0] GRP_DT  = 4'h4;
    localparam logic [3:0] GRP_UN  = 4'h6;
    localparam logic [3:0] GRP_SUB = 4'h3;

    assign rn = instr[8 +: IDX_W];
    assign rm = instr[4 +: IDX_W];

    // Pick the operation from the major group and the sub-code.
    always_comb begin
        op = OP_NONE;
        unique case (instr[15:12])
            GRP_DT:  if (instr[7:0] == 8'h10) op = OP_DT;
            GRP_UN: begin
                case (instr[3:0])
                    4'hE:    op = OP_EXTSB;
                    4'hF:    op = OP_EXTSW;
                    4'hC:    op = OP_EXTUB;
                    4'hD:    op = OP_EXTUW;
                    4'hB:    op = OP_NEG;
                    4'hA:    op = OP_NEGC;
                    default: op = OP_NONE;
                endcase
            end
            GRP_SUB: begin
                case (instr[3:0])
                    4'h8:    op = OP_SUB;
                    4'hA:    op = OP_SUBC;
                    4'hB:    op = OP_SUBV;
                    default: op = OP_NONE;
                endcase
            end
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/sne_alu.sv
// sne_alu: combinational datapath for all operations of the unit.
// Operand a is the destination register's value and b the source's.
// t_we marks the operations that update T.
module sne_alu
    import sne_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  sne_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              t_in,
    output logic [DATA_W-1:0] res,
    output logic              t_out,
    output logic              t_we
);
    localparam int HALF_W = 2 * BYTE_W;

    logic [DATA_W:0] diff_ext;   // carries the borrow in its top bit
    logic [DATA_W:0] minuend;
    logic [DATA_W:0] subtrahend;
    logic [DATA_W:0] borrow_in;

    // Select the operands of the shared wide subtractor.
    always_comb begin
        minuend    = {1'b0, a};
        subtrahend = {1'b0, b};
        borrow_in  = '0;
        case (op)
            OP_DT:        subtrahend = {{DATA_W{1'b0}}, 1'b1};
            OP_NEG:       minuend    = '0;
            OP_NEGC: begin
                minuend   = '0;
                borrow_in = {{DATA_W{1'b0}}, t_in};
            end
            OP_SUBC:      borrow_in  = {{DATA_W{1'b0}}, t_in};
            default:      ;
        endcase
        diff_ext = minuend - subtrahend - borrow_in;
    end

    // Form the result and the T update for each operation.
    always_comb begin
        res   = diff_ext[DATA_W-1:0];
        t_out = t_in;
        t_we  = 1'b0;
        case (op)
            OP_DT: begin
                t_we  = 1'b1;
                t_out = (diff_ext[DATA_W-1:0] == '0);
            end
            OP_EXTSB: res = {{(DATA_W-BYTE_W){b[BYTE_W-1]}}, b[BYTE_W-1:0]};
            OP_EXTSW: res = {{(DATA_W-HALF_W){b[HALF_W-1]}}, b[HALF_W-1:0]};
            OP_EXTUB: res = {{(DATA_W-BYTE_W){1'b0}}, b[BYTE_W-1:0]};
            OP_EXTUW: res = {{(DATA_W-HALF_W){1'b0}}, b[HALF_W-1:0]};
            OP_NEGC, OP_SUBC: begin
                t_we  = 1'b1;
                t_out = diff_ext[DATA_W];
            end
            OP_SUBV: begin
                t_we  = 1'b1;
                t_out = (a[DATA_W-1] != b[DATA_W-1]) &&
                        (diff_ext[DATA_W-1] != a[DATA_W-1]);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sne_regfile.sv
// sne_regfile: register file with two operand read ports, one peek port,
// an instruction write port and an external write port.
// Assumes the instruction port has priority when both ports hit one entry.
// All entries clear on synchronous active-low reset.
module sne_regfile #(
    parameter int DATA_W  = 32,
    parameter int REG_CNT = 16,
    parameter int IDX_W   = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic [IDX_W-1:0]  rc_idx,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data,
    output logic [DATA_W-1:0] rc_data,
    input  logic              wi_en,
    input  logic [IDX_W-1:0]  wi_idx,
    input  logic [DATA_W-1:0] wi_data,
    input  logic              wx_en,
    input  logic [IDX_W-1:0]  wx_idx,
    input  logic [DATA_W-1:0] wx_data
);
    logic [DATA_W-1:0] mem [REG_CNT];

    for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
        // Update one entry: reset, instruction write, then external write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wi_en && wi_idx == IDX_W'(g))
                mem[g] <= wi_data;
            else if (wx_en && wx_idx == IDX_W'(g))
                mem[g] <= wx_data;
        end
    end

    assign ra_data = mem[ra_idx];
    assign rb_data = mem[rb_idx];
    assign rc_data = mem[rc_idx];

    AST_INSTR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wi_en && wx_en && wi_idx == wx_idx |=> mem[$past(wi_idx)] == $past(wi_data)); // R12
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wi_en |=> mem[$past(wi_idx)] == $past(wi_data)); // R13
    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wi_en && !wx_en |=> mem[$past(rc_idx)] == $past(rc_data)); // R9
endmodule

// File: rtl/sne_unit.sv
// sne_unit: top of the subtract/negate/extend execution unit.
// Decodes one word per cycle, reads Rn and Rm, computes in one cycle and
// writes back at the next edge together with T. Assumes a synchronous
// active-low reset.
module sne_unit
    import sne_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int REG_CNT = 16,
    parameter int IDX_W   = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr,
    input  logic              ext_we,
    input  logic [IDX_W-1:0]  ext_idx,
    input  logic [DATA_W-1:0] ext_data,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic [DATA_W-1:0] peek_data,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_data,
    output logic              t_flag
);
    sne_op_e           op;
    logic [IDX_W-1:0]  rn_idx;
    logic [IDX_W-1:0]  rm_idx;
    logic [DATA_W-1:0] rn_data;
    logic [DATA_W-1:0] rm_data;
    logic              t_next;
    logic              t_upd;

    sne_decode #(.IDX_W(IDX_W)) u_dec (
        .instr (instr),
        .op    (op),
        .rn    (rn_idx),
        .rm    (rm_idx)
    );

    sne_alu #(.DATA_W(DATA_W)) u_alu (
        .op    (op),
        .a     (rn_data),
        .b     (rm_data),
        .t_in  (t_flag),
        .res   (wb_data),
        .t_out (t_next),
        .t_we  (t_upd)
    );

    assign wb_en = instr_valid && (op != OP_NONE);

    sne_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT), .IDX_W(IDX_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (rn_idx),
        .rb_idx  (rm_idx),
        .rc_idx  (peek_idx),
        .ra_data (rn_data),
        .rb_data (rm_data),
        .rc_data (peek_data),
        .wi_en   (wb_en),
        .wi_idx  (rn_idx),
        .wi_data (wb_data),
        .wx_en   (ext_we),
        .wx_idx  (ext_idx),
        .wx_data (ext_data)
    );

    // Hold the T bit; load it only for operations that define it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            t_flag <= 1'b0;
        else if (wb_en && t_upd)
            t_flag <= t_next;
    end

    AST_T_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid || op inside {OP_NONE, OP_NEG, OP_SUB, OP_EXTSB, OP_EXTSW,
                                    OP_EXTUB, OP_EXTUW}) |=> $stable(t_flag)); // R9
    AST_DT_ZERO_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && op == OP_DT |=> t_flag == ($past(wb_data) == '0)); // R1
    AST_EXTU_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && op == OP_EXTUB |-> wb_data[DATA_W-1:8] == '0); // R3
    AST_NEGC_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && op == OP_NEGC && rm_data == '0 && !t_flag |=> !t_flag); // R5
    AST_SUBV_SAME_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && op == OP_SUBV && rn_data[DATA_W-1] == rm_data[DATA_W-1]
        |=> !t_flag); // R8
endmodule

// File: tb/sne_unit_tb.sv
// sne_unit_tb: table of vectors (R1 <- op(R1, R2)) walked by a loop,
// then directed tests for reset, aliasing and port collisions.
module sne_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [15:0] instr;
    logic        ext_we;
    logic [3:0]  ext_idx;
    logic [31:0] ext_data;
    logic [3:0]  peek_idx;
    logic [31:0] peek_data;
    logic        wb_en;
    logic [31:0] wb_data;
    logic        t_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sne_unit u_dut (
        .clk, .rst_n, .instr_valid, .instr, .ext_we, .ext_idx, .ext_data,
        .peek_idx, .peek_data, .wb_en, .wb_data, .t_flag
    );

    typedef struct packed {
        logic [15:0] op;
        logic [31:0] a;
        logic [31:0] b;
        logic        tin;
        logic [31:0] er;
        logic        et;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{16'h4110, 32'h1,        32'h0,        1'b0, 32'h0,        1'b1}, // R1
        '{16'h4110, 32'h0,        32'h0,        1'b1, 32'hFFFFFFFF, 1'b0}, // R1
        '{16'h612E, 32'h0,        32'h00000080, 1'b0, 32'hFFFFFF80, 1'b0}, // R2
        '{16'h612E, 32'h0,        32'h1234567F, 1'b1, 32'h0000007F, 1'b1}, // R2
        '{16'h612F, 32'h0,        32'h00018000, 1'b0, 32'hFFFF8000, 1'b0}, // R2
        '{16'h612C, 32'h0,        32'hFFFFFF80, 1'b1, 32'h00000080, 1'b1}, // R3
        '{16'h612D, 32'h0,        32'hFFFF8001, 1'b0, 32'h00008001, 1'b0}, // R3
        '{16'h612B, 32'h0,        32'h1,        1'b1, 32'hFFFFFFFF, 1'b1}, // R4
        '{16'h612B, 32'h9,        32'h0,        1'b0, 32'h0,        1'b0}, // R4
        '{16'h612A, 32'h0,        32'h0,        1'b0, 32'h0,        1'b0}, // R5
        '{16'h612A, 32'h0,        32'h0,        1'b1, 32'hFFFFFFFF, 1'b1}, // R5
        '{16'h612A, 32'h0,        32'h1,        1'b0, 32'hFFFFFFFF, 1'b1}, // R5
        '{16'h3128, 32'h5,        32'h7,        1'b1, 32'hFFFFFFFE, 1'b1}, // R6
        '{16'h312A, 32'h5,        32'h3,        1'b1, 32'h1,        1'b0}, // R7
        '{16'h312A, 32'h3,        32'h3,        1'b1, 32'hFFFFFFFF, 1'b1}, // R7
        '{16'h312A, 32'h0,        32'hFFFFFFFF, 1'b0, 32'h1,        1'b1}, // R7
        '{16'h312B, 32'h80000000, 32'h1,        1'b0, 32'h7FFFFFFF, 1'b1}, // R8
        '{16'h312B, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0, 32'h80000000, 1'b1}, // R8
        '{16'h312B, 32'h5,        32'h3,        1'b1, 32'h2,        1'b0}, // R8
        '{16'h312B, 32'hFFFFFFFE, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF, 1'b0}, // R8
        '{16'h3129, 32'h1234,     32'h5,        1'b1, 32'h1234,     1'b1}, // R9
        '{16'h0000, 32'hABCD,     32'h5,        1'b0, 32'hABCD,     1'b0}  // R9
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic ext_write(input logic [3:0] idx, input logic [31:0] val);
        ext_we = 1'b1; ext_idx = idx; ext_data = val;
        @(posedge clk); @(negedge clk);
        ext_we = 1'b0;
    endtask

    task automatic run(input logic [15:0] w);
        instr_valid = 1'b1; instr = w;
        @(posedge clk); @(negedge clk);
        instr_valid = 1'b0;
    endtask

    // Use a decrement on R3 to force T: from 1 gives T=1, from 2 gives T=0 (R1).
    task automatic force_t(input logic v);
        ext_write(4'd3, v ? 32'd1 : 32'd2);
        run(16'h4310);
    endtask

    task automatic peek(input logic [3:0] idx, output logic [31:0] v);
        peek_idx = idx; #1; v = peek_data;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        rst_n = 1'b0; instr_valid = 1'b0; instr = '0;
        ext_we = 1'b0; ext_idx = '0; ext_data = '0; peek_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R11: reset state
        check("R11 T", {31'b0, t_flag}, 32'h0);
        for (int i = 0; i < 16; i++) begin
            peek(4'(i), v); check("R11 reg", v, 32'h0);
        end

        // Vector table: R1 = a, R2 = b, T = tin, then one instruction (R13)
        for (int k = 0; k < NV; k++) begin
            ext_write(4'd1, VECS[k].a);
            ext_write(4'd2, VECS[k].b);
            force_t(VECS[k].tin);
            run(VECS[k].op);
            peek(4'd1, v);
            check($sformatf("R13 vec%0d result", k), v, VECS[k].er);
            check($sformatf("R13 vec%0d T", k), {31'b0, t_flag}, {31'b0, VECS[k].et});
            peek(4'd2, v);
            check($sformatf("R13 vec%0d source kept", k), v, VECS[k].b);
        end

        // R9: valid low with a legal word writes nothing
        ext_write(4'd1, 32'h55); force_t(1'b1);
        instr = 16'h3128; instr_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        peek(4'd1, v); check("R9 valid low reg", v, 32'h55);
        check("R9 valid low T", {31'b0, t_flag}, 32'h1);

        // R10: aliased operands read the old value
        ext_write(4'd4, 32'h5);
        run(16'h3448);
        peek(4'd4, v); check("R10 sub self", v, 32'h0);
        ext_write(4'd4, 32'h7);
        run(16'h644B);
        peek(4'd4, v); check("R10 neg self", v, 32'hFFFFFFF9);
        ext_write(4'd4, 32'h9); force_t(1'b1);
        run(16'h344A);
        peek(4'd4, v); check("R10 subc self", v, 32'hFFFFFFFF);
        check("R10 subc self T", {31'b0, t_flag}, 32'h1);

        // R12: same-register collision, instruction wins
        ext_write(4'd1, 32'h10); ext_write(4'd2, 32'h3);
        ext_we = 1'b1; ext_idx = 4'd1; ext_data = 32'hDEAD;
        run(16'h3128);
        ext_we = 1'b0;
        peek(4'd1, v); check("R12 collision", v, 32'hD);

        // R12: different registers, both land
        ext_we = 1'b1; ext_idx = 4'd5; ext_data = 32'hBEEF;
        run(16'h3128);
        ext_we = 1'b0;
        peek(4'd1, v); check("R12 both instr", v, 32'hA);
        peek(4'd5, v); check("R12 both ext", v, 32'hBEEF);

        // R11: mid-run reset clears state
        force_t(1'b1);
        rst_n = 1'b0; @(posedge clk); @(negedge clk); rst_n = 1'b1;
        check("R11 T after reset", {31'b0, t_flag}, 32'h0);
        peek(4'd5, v); check("R11 reg after reset", v, 32'h0);
        peek(4'd1, v); check("R11 reg1 after reset", v, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule